// File: doc/BRIEF.md
# Two-Beat Burst Static Memory with Split Read and Write Ports

This block models a static memory with a dedicated read path and a dedicated write path. Every access is a burst of two words. A command arrives once per command period. Data moves in each half of that period. The block has a single clock that runs at twice the command rate. An internal half flag, brought out on `half`, marks which half-period the next rising edge closes. Commands are sampled only at edges where `half` is 0.

A write command latches one address A. The data on the command edge goes to A. The data on the following edge goes to A+1. A read command also latches one address A. The word at A appears three edges later and the word at A+1 appears one edge after that. Each data beat carries its own active-low lane mask. A read that meets a write to the same word on the same edge returns the new data in the lanes being written. A read and a write may be issued together.

Top module: `qdr_burst_sram`

## Requirements
- R1: After reset `rvalid` is 0, `rdata` is all zeros and `half` is 0.
- R2: `half` alternates on every edge after reset. `rd_n`, `wr_n` and `addr` are sampled only at edges where `half` is 0. Select levels at the other edges start nothing.
- R3: With `wr_n` low at a command edge, `wdata` at that edge is stored at `addr`. `wdata` at the next edge is stored at `addr`+1. No second address is taken.
- R4: With `rd_n` low at command edge t, the word at A is on `rdata` with `rvalid` high after edge t+3. The word at A+1 is on `rdata` after edge t+4.
- R5: Lane i is bits [i*DW/LANES +: DW/LANES], so with the defaults lane 0 is bits 8:0 and lane 1 is bits 17:9. A beat stores lane i only when `be_n[i]` is 0. With `be_n[i]` = 1 that lane is left unchanged, and with all bits 1 the beat stores nothing.
- R6: `be_n` is sampled with each beat, so the two beats of one burst may use different masks.
- R7: The second burst address is A+1 modulo 2**AW, so a burst at the last word continues at word 0.
- R8: When no read beat is due, `rvalid` is 0 and `rdata` is zero. At edges with neither select low, `wdata` and `be_n` change no stored word.
- R9: A read and a write may be accepted at the same command edge. When a read beat and a write beat address the same word on the same edge, the lanes being written return the new data.
- R10: Read commands on consecutive command edges give an unbroken stream of `rvalid`. The first beat of each burst comes right after an edge that leaves `half` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Active-low read select, sampled at command edges |
| wr_n | input | 1 | Active-low write select, sampled at command edges |
| addr | input | AW | Burst start address |
| wdata | input | DW | Write data, one beat per edge |
| be_n | input | LANES | Active-low lane write mask, one per beat |
| half | output | 1 | 0 when the next edge is a command edge |
| rdata | output | DW | Read data, one beat per edge |
| rvalid | output | 1 | High while `rdata` holds a read beat (low models high impedance) |

## Verification
The latency properties assume that the selects are sampled only when `half` is 0. They also assume that reset is released once and then held inactive, so the four- and five-edge windows after a read command are not cut short. The stimulus drives every input at the falling edge and reads `half` to place commands. It fills every word before the first read. At off-half edges it still randomizes the selects, so that those levels are seen to have no effect. Addresses are often drawn from a handful of low words and the top words, so that same-word overlaps and wrap-around occur often.

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
  parameter int DW    = 18,
  parameter int LANES = 2,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] be_n,
  output logic             half,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);
  localparam int LW    = DW / LANES;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          rd_s1, rd_s2, b1_pend, w_pend;
  logic [AW-1:0] ra1, ra2, b1_addr, w_addr;

  logic          cmd_edge;
  logic          wen, ren;
  logic [AW-1:0] wa, ra;
  logic [DW-1:0] fwd;

  assign cmd_edge = !half;
  assign wen      = cmd_edge ? !wr_n : w_pend;
  assign wa       = cmd_edge ? addr  : w_addr;
  assign ren      = cmd_edge ? b1_pend : rd_s2;
  assign ra       = cmd_edge ? b1_addr : ra2;

  always_comb begin
    fwd = mem[ra];
    for (int i = 0; i < LANES; i++)
      if (wen && wa == ra && !be_n[i])
        fwd[i*LW +: LW] = wdata[i*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (rst_n && wen)
      for (int i = 0; i < LANES; i++)
        if (!be_n[i])
          mem[wa][i*LW +: LW] <= wdata[i*LW +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half    <= 1'b0;
      rd_s1   <= 1'b0;
      rd_s2   <= 1'b0;
      b1_pend <= 1'b0;
      w_pend  <= 1'b0;
      ra1     <= '0;
      ra2     <= '0;
      b1_addr <= '0;
      w_addr  <= '0;
      rdata   <= '0;
      rvalid  <= 1'b0;
    end else begin
      half   <= !half;
      rvalid <= ren;
      rdata  <= ren ? fwd : '0;
      if (cmd_edge) begin
        rd_s1   <= !rd_n;
        ra1     <= addr;
        w_pend  <= !wr_n;
        w_addr  <= addr + 1'b1;
        b1_pend <= 1'b0;
      end else begin
        rd_s2   <= rd_s1;
        ra2     <= ra1;
        b1_pend <= rd_s2;
        b1_addr <= ra2 + 1'b1;
        w_pend  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk #(
  parameter int DW    = 18,
  parameter int LANES = 2,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_n,
  input logic             wr_n,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic [LANES-1:0] be_n,
  input logic             half,
  input logic [DW-1:0]    rdata,
  input logic             rvalid
);
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);

  a_r2_half_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> half != $past(half));

  a_r4_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (!half && !rd_n) |-> ##4 (rvalid && !half));

  a_r4_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (!half && !rd_n) |-> ##5 (rvalid && half));

  a_r10_burst_start_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> !half);
endmodule

bind qdr_burst_sram qdr_burst_sram_chk #(.DW(DW), .LANES(LANES), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
  .wdata(wdata), .be_n(be_n), .half(half), .rdata(rdata), .rvalid(rvalid)
);

// File: tb/qdr_burst_sram_tb.sv
module qdr_burst_sram_tb_top;
  localparam int DW = 18;
  localparam int LANES = 2;
  localparam int AW = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic [DW-1:0]    wdata = '0;
  logic [LANES-1:0] be_n = '1;
  logic             half;
  logic [DW-1:0]    rdata;
  logic             rvalid;

  always #4 clk = !clk;

  qdr_burst_sram #(.DW(DW), .LANES(LANES), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .be_n(be_n), .half(half), .rdata(rdata), .rvalid(rvalid)
  );

  int checks = 0, fails = 0, n = 0;
  bit done = 0;
  bit bh = 0;
  bit wpend_m = 0;
  logic [AW-1:0] wa_m;
  logic [DW-1:0] ref_mem [256];
  bit            sched_v [8];
  logic [AW-1:0] sched_a [8];
  string tag = "";

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) edge %0d: actual %h expected %h", req, tag, n, act, exp);
    end
  endtask

  task automatic wr_ref(logic [AW-1:0] a, logic [DW-1:0] d, logic [LANES-1:0] m);
    for (int i = 0; i < LANES; i++)
      if (!m[i]) ref_mem[a][i*9 +: 9] = d[i*9 +: 9];
  endtask

  task automatic step(bit c_rd, bit c_wr, logic [AW-1:0] c_a, logic [DW-1:0] d, logic [LANES-1:0] m);
    bit ev;
    logic [DW-1:0] ed;
    rd_n = !c_rd; wr_n = !c_wr; addr = c_a; wdata = d; be_n = m;
    if (!bh) begin
      if (c_wr) begin
        wr_ref(c_a, d, m);
        wpend_m = 1;
        wa_m = c_a + 8'd1;
      end else wpend_m = 0;
      if (c_rd) begin
        sched_v[(n+3)%8] = 1; sched_a[(n+3)%8] = c_a;
        sched_v[(n+4)%8] = 1; sched_a[(n+4)%8] = c_a + 8'd1;
      end
    end else begin
      if (wpend_m) wr_ref(wa_m, d, m);
      wpend_m = 0;
    end
    ev = sched_v[n%8];
    ed = ev ? ref_mem[sched_a[n%8]] : '0;
    sched_v[n%8] = 0;
    @(posedge clk);
    @(negedge clk);
    bh = !bh;
    n++;
    chk("R4", {31'd0, rvalid}, {31'd0, ev});
    chk(ev ? "R4" : "R8", {14'd0, rdata}, {14'd0, ed});
    chk("R2", {31'd0, half}, {31'd0, bh});
  endtask

  task automatic burst(bit r, bit w, logic [AW-1:0] a, logic [DW-1:0] d0, logic [LANES-1:0] m0,
                       logic [DW-1:0] d1, logic [LANES-1:0] m1);
    step(r, w, a, d0, m0);
    step(bit'($urandom % 2), bit'($urandom % 2), AW'($urandom), d1, m1);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++)
      burst(0, 0, AW'($urandom), DW'($urandom), LANES'($urandom), DW'($urandom), LANES'($urandom));
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int s = $urandom % 3;
    if (s == 0) return AW'($urandom % 8);
    if (s == 1) return AW'(252 + $urandom % 4);
    return AW'($urandom);
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 8; i++) sched_v[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R1 reset";
    chk("R1", {31'd0, rvalid}, 32'd0);
    chk("R1", {14'd0, rdata}, 32'd0);
    chk("R1", {31'd0, half}, 32'd0);

    tag = "R3 fill";
    for (int a = 0; a < 256; a += 2)
      burst(0, 1, AW'(a), DW'($urandom), 2'b00, DW'($urandom), 2'b00);
    tag = "R3 readback";
    for (int a = 0; a < 12; a++) burst(1, 0, AW'(a * 7), '0, '1, '0, '1);
    idle(3);

    tag = "R8 nop ignores wdata";
    idle(6);
    burst(1, 0, 8'd20, '0, '1, '0, '1);
    idle(3);

    tag = "R5 lane masks";
    burst(0, 1, 8'd30, 18'h3ffff, 2'b10, 18'h00000, 2'b01);
    burst(0, 1, 8'd32, 18'h15555, 2'b11, 18'h2aaaa, 2'b00);
    burst(1, 0, 8'd30, '0, '1, '0, '1);
    burst(1, 0, 8'd32, '0, '1, '0, '1);
    idle(3);

    tag = "R6 per-beat masks";
    burst(0, 1, 8'd10, 18'h12345, 2'b10, 18'h0abcd, 2'b01);
    burst(1, 0, 8'd10, '0, '1, '0, '1);
    idle(3);

    tag = "R7 wrap";
    burst(0, 1, 8'd255, 18'h1f00f, 2'b00, 18'h00ff0, 2'b00);
    burst(1, 0, 8'd255, '0, '1, '0, '1);
    idle(3);

    tag = "R9 same command";
    burst(1, 1, 8'd40, 18'h11111, 2'b00, 18'h22222, 2'b00);
    idle(3);
    tag = "R9 forward";
    burst(1, 0, 8'd50, '0, '1, '0, '1);
    burst(0, 1, 8'd49, 18'h33333, 2'b11, 18'h0c0c0, 2'b10);
    burst(0, 1, 8'd51, 18'h2d2d2, 2'b01, 18'h00000, 2'b11);
    idle(3);

    tag = "R10 back-to-back";
    for (int i = 0; i < 5; i++) burst(1, 0, AW'(100 + i), '0, '1, '0, '1);
    idle(3);

    tag = "random";
    for (int i = 0; i < 1500; i++)
      burst(bit'($urandom % 2), bit'($urandom % 2), pick_addr(), DW'($urandom),
            LANES'($urandom), DW'($urandom), LANES'($urandom));
    idle(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule